// File: doc/BRIEF.md
# Protected Bit-Update Register Bank

This block holds a small bank of 16-bit status and control words. Software reaches them in two ways. A word write replaces a whole word in one cycle. A bit command (clear, set, toggle or move) changes one bit, or a masked group of bits, through a two-phase read-modify-write. Each stored bit also has a hardware-set request line, such as an interrupt flag. That line can rise in any cycle, including between the read and the write-back of a bit command.

The write-back is masked. It changes only the bits the command names, and it merges them into the word's *live* contents, not into the copy taken during the read phase. A hardware event that lands mid-sequence on any other bit therefore survives. When hardware and software hit the same bit in the same cycle, software decides the result.

An address decoder sorts each address into a region:

| Address bits | Meaning |
|---|---|
| top bit | external |
| next three bits | region |
| low `IDX_W` bits | word within the region |

The regions are:

| Code | Region | Word access | Bit commands |
|---|---|---|---|
| 0 | lower special words | yes | no (error) |
| 1 | upper special words | yes | yes |
| 2 | extended special words | yes | yes |
| 3 | bit-capable RAM | yes | yes |
| 4 | plain RAM | yes | no (error) |
| 5 | register window onto region 4 | yes | yes |
| 6, 7 | unmapped | ignored | error |

The external space behaves like codes 6 and 7: word writes are ignored and bit commands raise the error.

The controller has three named states:

| State | Meaning |
|---|---|
| `ST_IDLE` | accepts word writes and bit commands |
| `ST_READ` | captures the target word |
| `ST_WRITE` | commits the masked result |

Its transitions are:

- **IDLE→READ**: a legal bit command is accepted.
- **READ→WRITE**: always taken after one cycle.
- **WRITE→IDLE**: always taken after one cycle.
- **IDLE→IDLE**: taken on a word write, an illegal bit command, or no command.

Top module: `prb_regbank`

## Requirements
- R1: A synchronous active-high reset clears every word, `busy` and `err`. Hardware-set requests present while reset is high leave no trace after reset.
- R2: A word write accepted in `ST_IDLE` replaces the whole addressed word at the next clock edge, in every mapped region (codes 0 to 5). A word write to an external address or to codes 6 or 7 changes no word.
- R3: A legal bit command accepted at edge N puts the block in `ST_READ` with `busy` high after N. It moves to `ST_WRITE`, still busy, after N+1. The result becomes visible and `busy` falls after N+2.
- R4: Single-bit operation codes are 00 clear, 01 set, 10 toggle and 11 move. Move copies bit 0 of the command data into the bit named by the 4-bit index.
- R5: In field mode the 16-bit command mask names the affected bits, and the same four codes apply to every masked bit. Move takes each masked bit from the same position of the command data.
- R6: The write-back leaves every unnamed bit at its live value. This includes bits that hardware set during `ST_READ` or `ST_WRITE`.
- R7: When a hardware set and a write-back target the same bit in the same cycle, the bit takes the software value.
- R8: A hardware set to a word in the same cycle as a word write to that word is lost.
- R9: A bit command to code 0, code 4, codes 6 and 7, or an external address raises `err` for exactly one cycle. It changes no word and does not raise `busy`.
- R10: The register window (code 5) reaches the plain-RAM word with the same index, for both word writes and bit commands.
- R11: Commands presented while `busy` is high are ignored.
- R12: Outside a conflicting software write, a hardware-set request sets its bit at the next edge and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_is_word | input | 1 | 1 = word write, 0 = bit command |
| cmd_is_field | input | 1 | Bit command uses `cmd_mask` instead of `cmd_bit` |
| cmd_op | input | 2 | 00 clear, 01 set, 10 toggle, 11 move |
| cmd_addr | input | ADDR_W (5) | {external, region[2:0], word index} |
| cmd_bit | input | BIT_W (4) | Bit index for single-bit commands |
| cmd_mask | input | DATA_W (16) | Field mask |
| cmd_wdata | input | DATA_W (16) | Word data, or move source |
| hw_set | input | HW_W (160) | Hardware-set requests; stored word w, bit b at w*16+b |
| rd_addr | input | ADDR_W (5) | Read address, same encoding as `cmd_addr` |
| rd_data | output | DATA_W (16) | Live word at `rd_addr`, zero when unmapped |
| busy | output | 1 | Read-modify-write in progress |
| err | output | 1 | One-cycle pulse for a rejected bit command |

## Verification
A wrong state register shows within one cycle. `busy` would fail to stay high for exactly two cycles, or the result would appear a cycle early or late.

A write-back built from the read-phase copy instead of the live word shows up three edges after a command. The bench injects a hardware set in `ST_READ` or `ST_WRITE`, and that set would be missing from `rd_data`. A wrong merge priority shows the hardware value on the targeted bit.

A decoder error shows in the same cycle:

- a spurious or missing `err` pulse one edge after the command;
- the wrong word changing when read back through the combinational read port;
- register-window writes failing to appear at the plain-RAM address.

// File: rtl/prb_pkg.sv
package prb_pkg;

    typedef enum logic [1:0] {
        OP_CLR = 2'b00,
        OP_SET = 2'b01,
        OP_TGL = 2'b10,
        OP_MOV = 2'b11
    } bit_op_e;

    typedef enum logic [2:0] {
        RG_SFR_LO    = 3'd0,
        RG_SFR_HI    = 3'd1,
        RG_ESFR      = 3'd2,
        RG_RAM_BIT   = 3'd3,
        RG_RAM_PLAIN = 3'd4,
        RG_GPR       = 3'd5,
        RG_GAP6      = 3'd6,
        RG_GAP7      = 3'd7
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rmw_state_e;

    // regions with their own storage: codes 0..4
    localparam int STORED_REGIONS = 5;

endpackage

// File: rtl/prb_addr_decode.sv
module prb_addr_decode
    import prb_pkg::*;
#(
    parameter  int IDX_W  = 1,
    localparam int ADDR_W = IDX_W + 4,
    localparam int WSEL_W = $clog2(STORED_REGIONS * (1 << IDX_W))
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped,
    output logic              bit_ok,
    output logic [WSEL_W-1:0] sel
);

    region_e          rg;
    logic             ext;
    logic [IDX_W-1:0] idx;
    int               base;

    always_comb begin
        ext    = addr[ADDR_W-1];
        rg     = region_e'(addr[IDX_W+2:IDX_W]);
        idx    = addr[IDX_W-1:0];
        mapped = 1'b0;
        bit_ok = 1'b0;
        base   = 0;
        unique case (rg)
            RG_SFR_LO, RG_RAM_PLAIN: begin
                mapped = 1'b1;
                base   = int'(rg);
            end
            RG_SFR_HI, RG_ESFR, RG_RAM_BIT: begin
                mapped = 1'b1;
                bit_ok = 1'b1;
                base   = int'(rg);
            end
            RG_GPR: begin
                // register window: always bit-capable, storage in plain RAM
                mapped = 1'b1;
                bit_ok = 1'b1;
                base   = int'(RG_RAM_PLAIN);
            end
            default: begin
                mapped = 1'b0;
                bit_ok = 1'b0;
            end
        endcase
        if (ext) begin
            mapped = 1'b0;
            bit_ok = 1'b0;
        end
        sel = WSEL_W'(base * (1 << IDX_W) + int'(idx));
    end

endmodule

// File: rtl/prb_rmw_fsm.sv
module prb_rmw_fsm
    import prb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic cmd_is_word,
    input  logic cmd_mapped,
    input  logic cmd_bit_ok,
    output logic word_we,
    output logic load_cmd,
    output logic snap_en,
    output logic wb_en,
    output logic busy,
    output logic err
);

    rmw_state_e st, st_nx;
    logic       err_q;
    logic       bad_bit_cmd;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (cmd_valid && !cmd_is_word && cmd_bit_ok) st_nx = ST_READ;
            ST_READ:  st_nx = ST_WRITE;
            ST_WRITE: st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_we     = 1'b0;
        load_cmd    = 1'b0;
        snap_en     = 1'b0;
        wb_en       = 1'b0;
        busy        = 1'b1;
        bad_bit_cmd = 1'b0;
        unique case (st)
            ST_IDLE: begin
                busy        = 1'b0;
                word_we     = cmd_valid && cmd_is_word && cmd_mapped;
                load_cmd    = cmd_valid && !cmd_is_word && cmd_bit_ok;
                bad_bit_cmd = cmd_valid && !cmd_is_word && !cmd_bit_ok;
            end
            ST_READ:  snap_en = 1'b1;
            ST_WRITE: wb_en   = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bad_bit_cmd;
    end

    assign err = err_q;

    // R3: the read phase always leads to the write phase
    p_read_to_write_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_READ) |=> (st == ST_WRITE));

    // R3: the write phase always returns to idle
    p_write_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WRITE) |=> (st == ST_IDLE));

    // R9: a rejected command never starts a sequence
    p_err_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R11: no word write is taken while a sequence is running
    p_no_word_when_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !word_we);

endmodule

// File: rtl/prb_word.sv
module prb_word #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] hw_set,
    input  logic              word_we,
    input  logic [DATA_W-1:0] word_wdata,
    input  logic              wb_en,
    input  logic [DATA_W-1:0] wb_mask,
    input  logic [DATA_W-1:0] wb_value,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] live;
    logic [DATA_W-1:0] sw_mask;
    logic [DATA_W-1:0] keep;

    always_comb begin
        live = q | hw_set;
        if (word_we)    sw_mask = '1;
        else if (wb_en) sw_mask = wb_mask;
        else            sw_mask = '0;
        keep = hw_set & ~sw_mask;
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (word_we) q <= word_wdata;
        else if (wb_en)   q <= (live & ~wb_mask) | (wb_value & wb_mask);
        else              q <= live;
    end

    // R12: a hardware set not overridden by software lands in the word
    p_hw_kept_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(keep)) == $past(keep)));

    // R7: named bits take the software value
    p_sw_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !word_we) |=> ((q & $past(wb_mask)) == ($past(wb_value) & $past(wb_mask))));

    // R6: unnamed bits without a hardware event hold their value
    p_untargeted_r6: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !word_we) |=> (((q ^ $past(q)) & ~$past(wb_mask) & ~$past(hw_set)) == '0));

    // R8: a word write wins over a same-cycle hardware set
    p_word_write_r8: assert property (@(posedge clk) disable iff (rst)
        word_we |=> (q == $past(word_wdata)));

endmodule

// File: rtl/prb_regbank.sv
module prb_regbank
    import prb_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int IDX_W     = 1,
    localparam int ADDR_W    = IDX_W + 4,
    localparam int BIT_W     = $clog2(DATA_W),
    localparam int NUM_WORDS = STORED_REGIONS * (1 << IDX_W),
    localparam int HW_W      = NUM_WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_is_word,
    input  logic              cmd_is_field,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BIT_W-1:0]  cmd_bit,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [HW_W-1:0]   hw_set,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              err
);

    localparam int WSEL_W = $clog2(NUM_WORDS);

    logic              cmd_mapped, cmd_bit_ok;
    logic [WSEL_W-1:0] cmd_sel;
    logic              rd_mapped, rd_bit_ok_unused;
    logic [WSEL_W-1:0] rd_sel;
    logic              word_we, load_cmd, snap_en, wb_en;

    logic [WSEL_W-1:0] sel_q;
    bit_op_e           op_q;
    logic [DATA_W-1:0] mask_q, val_q, snap_q, mod_value;
    logic [DATA_W-1:0] words_q [NUM_WORDS];

    prb_addr_decode #(.IDX_W(IDX_W)) u_cmd_dec (
        .addr   (cmd_addr),
        .mapped (cmd_mapped),
        .bit_ok (cmd_bit_ok),
        .sel    (cmd_sel)
    );

    prb_addr_decode #(.IDX_W(IDX_W)) u_rd_dec (
        .addr   (rd_addr),
        .mapped (rd_mapped),
        .bit_ok (rd_bit_ok_unused),
        .sel    (rd_sel)
    );

    prb_rmw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_is_word (cmd_is_word),
        .cmd_mapped  (cmd_mapped),
        .cmd_bit_ok  (cmd_bit_ok),
        .word_we     (word_we),
        .load_cmd    (load_cmd),
        .snap_en     (snap_en),
        .wb_en       (wb_en),
        .busy        (busy),
        .err         (err)
    );

    // command latch
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            op_q   <= OP_CLR;
            mask_q <= '0;
            val_q  <= '0;
        end else if (load_cmd) begin
            sel_q  <= cmd_sel;
            op_q   <= bit_op_e'(cmd_op);
            mask_q <= cmd_is_field ? cmd_mask : (DATA_W'(1) << cmd_bit);
            val_q  <= cmd_is_field ? cmd_wdata : {DATA_W{cmd_wdata[0]}};
        end
    end

    // read phase: capture the addressed word
    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (snap_en) snap_q <= words_q[sel_q];
    end

    // modify
    always_comb begin
        unique case (op_q)
            OP_CLR:  mod_value = '0;
            OP_SET:  mod_value = '1;
            OP_TGL:  mod_value = ~snap_q;
            OP_MOV:  mod_value = val_q;
            default: mod_value = '0;
        endcase
    end

    // storage
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        prb_word #(.DATA_W(DATA_W)) u_word (
            .clk        (clk),
            .rst        (rst),
            .hw_set     (hw_set[w*DATA_W +: DATA_W]),
            .word_we    (word_we && (cmd_sel == WSEL_W'(w))),
            .word_wdata (cmd_wdata),
            .wb_en      (wb_en && (sel_q == WSEL_W'(w))),
            .wb_mask    (mask_q),
            .wb_value   (mod_value),
            .q          (words_q[w])
        );
    end

    assign rd_data = rd_mapped ? words_q[rd_sel] : '0;

    // R3: busy lasts exactly two cycles per sequence
    p_busy_two_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    // R9: an accepted bit command is never also rejected
    p_accept_excl_r9: assert property (@(posedge clk) disable iff (rst)
        load_cmd |=> !err);

endmodule

// File: tb/tb_prb_regbank.sv
module tb_prb_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0, cmd_is_word = 1'b0, cmd_is_field = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [4:0]    cmd_addr = '0;
    logic [3:0]    cmd_bit = '0;
    logic [DW-1:0] cmd_mask = '0, cmd_wdata = '0;
    logic [NW*DW-1:0] hw_set = '0;
    logic [4:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prb_regbank dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_word(cmd_is_word),
        .cmd_is_field(cmd_is_field), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_bit(cmd_bit), .cmd_mask(cmd_mask), .cmd_wdata(cmd_wdata),
        .hw_set(hw_set), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic word_wr(input logic [4:0] a, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_is_word = 1'b1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_is_word = 1'b0;
    endtask

    // returns at the negedge inside the read phase
    task automatic bit_start(input logic [4:0] a, input logic [1:0] op, input logic [3:0] b,
                             input logic fld, input logic [DW-1:0] m, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_is_word = 1'b0; cmd_is_field = fld; cmd_op = op;
        cmd_addr = a; cmd_bit = b; cmd_mask = m; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_is_field = 1'b0;
    endtask

    task automatic bit_run(input logic [4:0] a, input logic [1:0] op, input logic [3:0] b,
                           input logic fld, input logic [DW-1:0] m, input logic [DW-1:0] d);
        bit_start(a, op, b, fld, m, d);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        rst = 1'b1;
        hw_set = '1;
        repeat (3) @(negedge clk);
        hw_set = '0;
        rst = 1'b0;
        @(negedge clk);
        rd(5'd0, d);  chk("R1 word0", d, 16'h0);
        rd(5'd7, d);  chk("R1 word7", d, 16'h0);
        rd(5'd10, d); chk("R1 window", d, 16'h0);
        chk("R1 busy", {15'b0, busy}, 16'h0);
        chk("R1 err", {15'b0, err}, 16'h0);
    endtask

    task automatic t_word_write;
        logic [DW-1:0] d;
        word_wr(5'd0, 16'hA5C3);
        rd(5'd0, d); chk("R2 lower special", d, 16'hA5C3);
        word_wr(5'b1_000_0, 16'h1111);
        rd(5'd0, d); chk("R2 external ignored", d, 16'hA5C3);
        word_wr(5'b0_110_0, 16'h2222);
        rd(5'b0_110_0, d); chk("R2 unmapped reads zero", d, 16'h0);
        rd(5'd0, d); chk("R2 unmapped no alias", d, 16'hA5C3);
    endtask

    task automatic t_bit_seq;
        logic [DW-1:0] d;
        word_wr(5'd4, 16'h0000);
        bit_start(5'd4, 2'b01, 4'd3, 1'b0, '0, '0);
        chk("R3 busy in read", {15'b0, busy}, 16'h1);
        rd(5'd4, d); chk("R3 unchanged in read", d, 16'h0);
        @(negedge clk);
        chk("R3 busy in write", {15'b0, busy}, 16'h1);
        rd(5'd4, d); chk("R3 unchanged in write", d, 16'h0);
        @(negedge clk);
        chk("R3 busy dropped", {15'b0, busy}, 16'h0);
        rd(5'd4, d); chk("R3 R4 set result", d, 16'h0008);
    endtask

    task automatic t_ops;
        logic [DW-1:0] d;
        word_wr(5'd6, 16'h00F0);
        bit_run(5'd6, 2'b00, 4'd4, 1'b0, '0, '0);
        rd(5'd6, d); chk("R4 clear", d, 16'h00E0);
        bit_run(5'd6, 2'b10, 4'd0, 1'b0, '0, '0);
        rd(5'd6, d); chk("R4 toggle up", d, 16'h00E1);
        bit_run(5'd6, 2'b10, 4'd0, 1'b0, '0, '0);
        rd(5'd6, d); chk("R4 toggle down", d, 16'h00E0);
        bit_run(5'd6, 2'b11, 4'd15, 1'b0, '0, 16'h0001);
        rd(5'd6, d); chk("R4 move one", d, 16'h80E0);
        bit_run(5'd6, 2'b11, 4'd7, 1'b0, '0, 16'hFFFE);
        rd(5'd6, d); chk("R4 move zero", d, 16'h8060);
    endtask

    task automatic t_field;
        logic [DW-1:0] d;
        word_wr(5'd3, 16'h1234);
        bit_run(5'd3, 2'b01, 4'd0, 1'b1, 16'h0F00, '0);
        rd(5'd3, d); chk("R5 field set", d, 16'h1F34);
        bit_run(5'd3, 2'b11, 4'd0, 1'b1, 16'h00FF, 16'hAB5A);
        rd(5'd3, d); chk("R5 field move", d, 16'h1F5A);
        bit_run(5'd3, 2'b10, 4'd0, 1'b1, 16'hF000, '0);
        rd(5'd3, d); chk("R5 field toggle", d, 16'hEF5A);
        bit_run(5'd3, 2'b00, 4'd0, 1'b1, 16'h00F0, '0);
        rd(5'd3, d); chk("R5 field clear", d, 16'hEF0A);
    endtask

    task automatic t_midseq;
        logic [DW-1:0] d;
        word_wr(5'd7, 16'h0004);
        bit_start(5'd7, 2'b00, 4'd2, 1'b0, '0, '0);
        hw_set[7*DW + 9] = 1'b1;          // during read phase
        @(negedge clk);
        hw_set = '0;
        hw_set[7*DW + 11] = 1'b1;         // during write phase
        @(negedge clk);
        hw_set = '0;
        rd(5'd7, d); chk("R6 hardware sets survive write-back", d, 16'h0A00);
    endtask

    task automatic t_conflict;
        logic [DW-1:0] d;
        bit_start(5'd7, 2'b00, 4'd9, 1'b0, '0, '0);
        @(negedge clk);
        hw_set[7*DW + 9] = 1'b1;          // same bit, same cycle as write-back
        @(negedge clk);
        hw_set = '0;
        rd(5'd7, d); chk("R7 software wins", d, 16'h0800);
    endtask

    task automatic t_word_hw;
        logic [DW-1:0] d;
        hw_set[4*DW + 5] = 1'b1;
        word_wr(5'd4, 16'h0001);
        hw_set = '0;
        rd(5'd4, d); chk("R8 set lost to word write", d, 16'h0001);
        hw_set[4*DW + 5] = 1'b1;
        @(negedge clk);
        hw_set = '0;
        @(negedge clk);
        rd(5'd4, d); chk("R12 idle hardware set sticks", d, 16'h0021);
    endtask

    task automatic t_illegal;
        logic [DW-1:0] d;
        bit_start(5'd0, 2'b01, 4'd2, 1'b0, '0, '0);
        chk("R9 err pulse", {15'b0, err}, 16'h1);
        chk("R9 not busy", {15'b0, busy}, 16'h0);
        @(negedge clk);
        chk("R9 err one cycle", {15'b0, err}, 16'h0);
        rd(5'd0, d); chk("R9 lower special unchanged", d, 16'hA5C3);
        word_wr(5'd8, 16'h0000);
        bit_start(5'd8, 2'b01, 4'd6, 1'b0, '0, '0);
        chk("R9 plain RAM err", {15'b0, err}, 16'h1);
        @(negedge clk);
        rd(5'd8, d); chk("R9 plain RAM unchanged", d, 16'h0);
        bit_start(5'b1_011_0, 2'b01, 4'd6, 1'b0, '0, '0);
        chk("R9 external err", {15'b0, err}, 16'h1);
        @(negedge clk);
        rd(5'd6, d); chk("R9 no alias on external", d, 16'h8060);
        bit_start(5'b0_111_1, 2'b01, 4'd0, 1'b0, '0, '0);
        chk("R9 unmapped err", {15'b0, err}, 16'h1);
        @(negedge clk);
    endtask

    task automatic t_gpr;
        logic [DW-1:0] d;
        bit_start(5'd10, 2'b01, 4'd6, 1'b0, '0, '0);
        chk("R10 window no err", {15'b0, err}, 16'h0);
        @(negedge clk);
        @(negedge clk);
        rd(5'd8, d); chk("R10 bit via window", d, 16'h0040);
        word_wr(5'd11, 16'hBEEF);
        rd(5'd9, d); chk("R10 word via window", d, 16'hBEEF);
    endtask

    task automatic t_busy_ignore;
        logic [DW-1:0] d;
        bit_start(5'd6, 2'b01, 4'd0, 1'b0, '0, '0);
        cmd_valid = 1'b1; cmd_is_word = 1'b1; cmd_addr = 5'd6; cmd_wdata = 16'hFFFF;
        @(negedge clk);
        cmd_is_word = 1'b0; cmd_op = 2'b00; cmd_bit = 4'd15; cmd_addr = 5'd6;
        @(negedge clk);
        cmd_valid = 1'b0;
        rd(5'd6, d); chk("R11 busy commands ignored", d, 16'h8061);
        chk("R11 no err", {15'b0, err}, 16'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_word_write();
        t_bit_seq();
        t_ops();
        t_field();
        t_midseq();
        t_conflict();
        t_word_hw();
        t_illegal();
        t_gpr();
        t_busy_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule